// File: doc/BRIEF.md
# Power Mode and Clock-Gating Controller

This block manages power for a chip that has one CPU, a set of gated peripheral clocks, three PLLs and five switchable power domains. Software picks a low-power mode with a single register write. The controller then drives the CPU clock enable, the per-peripheral clock enables, the three PLL enables and the five domain power requests into the pattern that the mode needs. A wake-up event brings the chip back to normal operation. When the chip leaves a mode that shut down the PLLs or removed power, the return follows a fixed order: power first, then the PLLs, then the clocks.

Two more registers sit next to the mode register. One holds a per-peripheral clock enable mask for general gating during normal running. The other holds a slow-clock select and the enable for the extra special-frequency PLL. The slow-clock select steers the clock muxes to the external reference, which bypasses the PLLs. The write port is a plain single-cycle strobe. It has no back-pressure: every write is taken in the cycle it is presented. All other pins are level control or status.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset behaviour. After reset the mode status is NORMAL (0), the gate mask is all ones, the slow select and the extra PLL enable are 0, and `pll_en` is 3'b011. All five domain requests are 1. The CPU and peripheral clock enables stay 0 until every enabled PLL reports lock, and they turn on in the cycle after lock is seen.
- R2: Gating in NORMAL. When running in NORMAL, `periph_clk_en[i]` equals bit i of the gate mask, which is written at address 1. `cpu_clk_en` is 1 and all domain requests are 1.
- R3: IDLE (code 1). `cpu_clk_en` is 0. The peripheral enables still follow the gate mask, and the PLL enables stay as they are in NORMAL.
- R4: STOP (code 2). All three PLL enables are 0, `cpu_clk_en` is 0 and every peripheral enable is 0. All domains stay powered.
- R5: DEEP-STOP (code 3). The outputs are the same as in STOP, except that the CPU domain request (bit 0) is 0. The four peripheral domain requests (bits 4:1) stay 1.
- R6: SLEEP (code 4). All five domain requests are 0, and all PLL enables and clock enables are 0. The wake-up logic keeps running on its own supply.
- R7: PLL enables. Bit 0 enables the CPU PLL and bit 1 enables the bus PLL; both are on in NORMAL and IDLE. Bit 2 enables the extra PLL and follows bit 1 of the clock config register (address 2) in those modes.
- R8: Slow-clock select. `clk_src_ext` follows bit 0 of the clock config register in every mode. When it is 1, the clock muxes take the external reference instead of the PLLs.
- R9: Mode entry. A write of code 0 to 4 at address 0 while running in NORMAL sets `pm_mode` and the matching outputs one clock later.
- R10: Ignored mode writes. A mode write with code 5, 6 or 7 is ignored. So is any mode write made while not running in NORMAL.
- R11: Wake from IDLE. A wake event in IDLE returns the controller to NORMAL, with the CPU clock on, one clock later.
- R12: Wake from STOP, DEEP-STOP or SLEEP. One clock after the wake event, `pm_mode` is NORMAL and all domain requests are 1, while PLLs and clocks stay off. This lasts SETTLE_CYC cycles. The configured PLLs are then enabled, and the clocks turn on in the cycle after every enabled PLL locks.
- R13: A wake event while in NORMAL has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 gate mask, 2 clock config |
| cfg_wdata | input | N_PERIPH | Write data |
| wake_evt | input | 1 | Wake-up event |
| pll_lock | input | 3 | Lock flags for the CPU, bus and extra PLLs |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| pll_en | output | 3 | Enables for the CPU, bus and extra PLLs |
| clk_src_ext | output | 1 | Selects the external slow reference for the clock muxes |
| dom_pwr_req | output | 5 | Domain power requests; bit 0 is the CPU domain |
| pm_mode | output | 3 | Current mode code |

## Verification
The hardest part to reach from the ports is the wake-up path out of the deeper modes. Its middle phases hide behind `pm_mode`, which already reads NORMAL, so they show only through the timing of the PLL enables and the clock enables. The bench sweeps every mode against two clock configurations. Around each wake it withholds lock, then asserts lock only partially, then fully. With the extra PLL enabled, this shows that the clocks wait for the last configured PLL and not just the two main ones.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NUM_DOM = 5;
  localparam int NUM_PLL = 3;
  localparam int CPU_DOM = 0;

  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_IDLE   = 3'd1,
    PM_STOP   = 3'd2,
    PM_DSTOP  = 3'd3,
    PM_SLEEP  = 3'd4
  } pm_mode_e;

  typedef enum logic [1:0] {
    PH_ACTIVE   = 2'd0,
    PH_PWRUP    = 2'd1,
    PH_LOCKWAIT = 2'd2
  } pm_phase_e;

  localparam logic [1:0] ADR_MODE   = 2'd0;
  localparam logic [1:0] ADR_GATE   = 2'd1;
  localparam logic [1:0] ADR_CLKCFG = 2'd2;

  function automatic logic mode_code_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [N_PERIPH-1:0] wr_data,
  output logic [N_PERIPH-1:0] gate_mask,
  output logic                slow_sel,
  output logic                xpll_on,
  output logic                mode_wr,
  output logic [2:0]          mode_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_mask <= '1;
      slow_sel  <= 1'b0;
      xpll_on   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADR_GATE) gate_mask <= wr_data;
      if (wr_addr == ADR_CLKCFG) begin
        slow_sel <= wr_data[0];
        xpll_on  <= wr_data[1];
      end
    end
  end

  assign mode_wr   = wr_en && (wr_addr == ADR_MODE);
  assign mode_code = wr_data[2:0];
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_wr,
  input  logic [2:0] mode_code,
  input  logic      wake,
  input  logic      locks_ok,
  output pm_mode_e  mode_q,
  output pm_phase_e phase_q
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_NORMAL;
      phase_q <= PH_LOCKWAIT;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_ACTIVE: begin
          if (mode_q == PM_NORMAL) begin
            if (mode_wr && mode_code_ok(mode_code))
              mode_q <= pm_mode_e'(mode_code);
          end else if (wake) begin
            mode_q <= PM_NORMAL;
            if (mode_q != PM_IDLE) begin
              phase_q <= PH_PWRUP;
              cnt_q   <= CNT_W'(SETTLE_CYC - 1);
            end
          end
        end
        PH_PWRUP: begin
          if (cnt_q == '0) phase_q <= PH_LOCKWAIT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_LOCKWAIT: begin
          if (locks_ok) phase_q <= PH_ACTIVE;
        end
        default: phase_q <= PH_ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/pmc_outmap.sv
module pmc_outmap
  import pmc_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  pm_mode_e             mode,
  input  pm_phase_e            phase,
  input  logic [N_PERIPH-1:0]  gate_mask,
  input  logic                 xpll_on,
  output logic                 cpu_en,
  output logic [N_PERIPH-1:0]  periph_en,
  output logic [NUM_PLL-1:0]   pll_en,
  output logic [NUM_PLL-1:0]   pll_need,
  output logic [NUM_DOM-1:0]   dom_req
);
  logic run, plls_mode, periph_mode;

  assign run         = (phase == PH_ACTIVE);
  assign plls_mode   = (mode == PM_NORMAL) || (mode == PM_IDLE);
  assign periph_mode = run && plls_mode;
  assign cpu_en      = run && (mode == PM_NORMAL);
  assign pll_need    = {xpll_on, 1'b1, 1'b1};
  assign pll_en      = (phase != PH_PWRUP && plls_mode) ? pll_need : '0;

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_periph
    assign periph_en[i] = periph_mode && gate_mask[i];
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == CPU_DOM) begin : g_cpu
      assign dom_req[d] = !(run && (mode == PM_SLEEP || mode == PM_DSTOP));
    end else begin : g_per
      assign dom_req[d] = !(run && mode == PM_SLEEP);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_PERIPH   = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [1:0]          cfg_addr,
  input  logic [N_PERIPH-1:0] cfg_wdata,
  input  logic                wake_evt,
  input  logic [2:0]          pll_lock,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic [2:0]          pll_en,
  output logic                clk_src_ext,
  output logic [4:0]          dom_pwr_req,
  output logic [2:0]          pm_mode
);
  logic [N_PERIPH-1:0] gate_mask;
  logic                slow_sel, xpll_on, mode_wr, locks_ok;
  logic [2:0]          mode_code;
  logic [NUM_PLL-1:0]  pll_need;
  pm_mode_e            mode_q;
  pm_phase_e           phase_q;

  pmc_regs #(.N_PERIPH(N_PERIPH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .gate_mask(gate_mask), .slow_sel(slow_sel),
    .xpll_on(xpll_on), .mode_wr(mode_wr), .mode_code(mode_code)
  );

  assign locks_ok = &(pll_lock | ~pll_need);

  pmc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .wake(wake_evt), .locks_ok(locks_ok), .mode_q(mode_q), .phase_q(phase_q)
  );

  pmc_outmap #(.N_PERIPH(N_PERIPH)) u_map (
    .mode(mode_q), .phase(phase_q), .gate_mask(gate_mask), .xpll_on(xpll_on),
    .cpu_en(cpu_clk_en), .periph_en(periph_clk_en), .pll_en(pll_en),
    .pll_need(pll_need), .dom_req(dom_pwr_req)
  );

  assign clk_src_ext = slow_sel;
  assign pm_mode     = mode_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int N_PERIPH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          pm_mode,
  input logic                cpu_clk_en,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input logic [2:0]          pll_en,
  input logic [4:0]          dom_pwr_req,
  input logic [N_PERIPH-1:0] gate_mask
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode <= 3'd4); // R9
  AST_NORMAL_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 3'd0 && cpu_clk_en) |-> periph_clk_en == gate_mask); // R2
  AST_IDLE_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode == 3'd1 |-> !cpu_clk_en && pll_en[1:0] == 2'b11); // R3
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode == 3'd2 |-> pll_en == 3'b000 && !cpu_clk_en && periph_clk_en == '0); // R4
  AST_DSTOP_CPU_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode == 3'd3 |-> dom_pwr_req == 5'b11110 && pll_en == 3'b000); // R5
  AST_SLEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode == 3'd4 |-> dom_pwr_req == 5'b00000 && pll_en == 3'b000); // R6
  AST_LOWPWR_EXIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode != 3'd0 |=> (pm_mode == $past(pm_mode) || pm_mode == 3'd0)); // R10
  AST_PLL_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en[1]) |-> dom_pwr_req == 5'h1F && $past(dom_pwr_req) == 5'h1F); // R12
  AST_CLK_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en[0]) |-> !cpu_clk_en); // R12
endmodule

bind pwr_mode_ctrl pmc_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pm_mode(pm_mode), .cpu_clk_en(cpu_clk_en),
  .periph_clk_en(periph_clk_en), .pll_en(pll_en), .dom_pwr_req(dom_pwr_req),
  .gate_mask(gate_mask)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int NP     = 8;
  localparam int SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [NP-1:0] cfg_wdata = '0;
  logic          wake_evt = 1'b0;
  logic [2:0]    pll_lock = '0;
  logic          cpu_clk_en, clk_src_ext;
  logic [NP-1:0] periph_clk_en;
  logic [2:0]    pll_en, pm_mode;
  logic [4:0]    dom_pwr_req;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.N_PERIPH(NP), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wake_evt(wake_evt), .pll_lock(pll_lock),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .pll_en(pll_en),
    .clk_src_ext(clk_src_ext), .dom_pwr_req(dom_pwr_req), .pm_mode(pm_mode)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wake_pulse();
    @(negedge clk);
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, waiting for lock
    chk("R1", "mode", 32'(pm_mode), 0);
    chk("R1", "cpu_en", 32'(cpu_clk_en), 0);
    chk("R1", "periph_en", 32'(periph_clk_en), 0);
    chk("R1", "pll_en", 32'(pll_en), 3'b011);
    chk("R1", "dom", 32'(dom_pwr_req), 5'h1F);
    chk("R1", "clk_src", 32'(clk_src_ext), 0);
    repeat (2) @(negedge clk);
    chk("R1", "cpu_en before lock", 32'(cpu_clk_en), 0);
    pll_lock = 3'b011;
    @(negedge clk);
    chk("R1", "cpu_en after lock", 32'(cpu_clk_en), 1);
    chk("R1", "gate reset all ones", 32'(periph_clk_en), 8'hFF);

    // R2 single-bit gating sweep plus patterns
    for (int k = 0; k < NP; k++) begin
      wr(2'd1, NP'(1) << k);
      chk("R2", "one-hot gate", 32'(periph_clk_en), 32'(1) << k);
    end
    wr(2'd1, 8'hA5); chk("R2", "gate A5", 32'(periph_clk_en), 8'hA5);
    wr(2'd1, 8'h00); chk("R2", "gate 00", 32'(periph_clk_en), 8'h00);
    chk("R2", "cpu stays on", 32'(cpu_clk_en), 1);
    chk("R2", "dom on", 32'(dom_pwr_req), 5'h1F);

    // R7 / R8 clock config sweep
    for (int c = 0; c < 4; c++) begin
      wr(2'd2, NP'(c));
      chk("R7", "pll_en cfg", 32'(pll_en), {c[1], 2'b11});
      chk("R8", "slow select", 32'(clk_src_ext), 32'(c[0]));
    end
    pll_lock = 3'b111;

    // R10 undefined codes
    for (int code = 5; code < 8; code++) begin
      wr(2'd0, NP'(code));
      chk("R10", "undefined code mode", 32'(pm_mode), 0);
      chk("R10", "undefined code cpu", 32'(cpu_clk_en), 1);
    end

    // R13 wake in NORMAL
    wake_pulse();
    chk("R13", "wake in normal mode", 32'(pm_mode), 0);
    chk("R13", "wake in normal cpu", 32'(cpu_clk_en), 1);
    chk("R13", "wake in normal pll", 32'(pll_en), 3'b111);

    // Mode sweep over two clock configurations
    for (int ci = 0; ci < 2; ci++) begin
      logic [1:0] cfg;
      logic [2:0] pexp;
      cfg  = (ci == 0) ? 2'b00 : 2'b11;
      pexp = {cfg[1], 2'b11};
      for (int m = 1; m <= 4; m++) begin
        logic [NP-1:0] pat;
        pat = NP'(8'h3C ^ (m * 17 + ci * 5));
        wr(2'd2, NP'(cfg));
        wr(2'd1, pat);
        pll_lock = pexp;
        wr(2'd0, NP'(m));
        chk("R9", "mode entry", 32'(pm_mode), 32'(m));
        chk("R8", "slow select held", 32'(clk_src_ext), 32'(cfg[0]));
        case (m)
          1: begin
            chk("R3", "idle cpu", 32'(cpu_clk_en), 0);
            chk("R3", "idle periph", 32'(periph_clk_en), 32'(pat));
            chk("R3", "idle pll", 32'(pll_en), 32'(pexp));
            chk("R3", "idle dom", 32'(dom_pwr_req), 5'h1F);
            wr(2'd0, NP'(2));
            chk("R10", "write in idle ignored", 32'(pm_mode), 1);
            wake_pulse();
            chk("R11", "idle wake mode", 32'(pm_mode), 0);
            chk("R11", "idle wake cpu", 32'(cpu_clk_en), 1);
            chk("R11", "idle wake periph", 32'(periph_clk_en), 32'(pat));
          end
          default: begin
            chk("R4", "stop-class cpu", 32'(cpu_clk_en), 0);
            chk("R4", "stop-class periph", 32'(periph_clk_en), 0);
            chk("R4", "stop-class pll", 32'(pll_en), 0);
            if (m == 2) chk("R4", "stop dom", 32'(dom_pwr_req), 5'h1F);
            if (m == 3) chk("R5", "deep-stop dom", 32'(dom_pwr_req), 5'h1E);
            if (m == 4) chk("R6", "sleep dom", 32'(dom_pwr_req), 5'h00);
            wr(2'd0, NP'(0));
            chk("R10", "write in low power ignored", 32'(pm_mode), 32'(m));
            pll_lock = 3'b000;
            wake_pulse();
            chk("R12", "wake mode", 32'(pm_mode), 0);
            chk("R12", "power first", 32'(dom_pwr_req), 5'h1F);
            chk("R12", "pll off in settle", 32'(pll_en), 0);
            for (int s = 1; s < SETTLE; s++) begin
              @(negedge clk);
              chk("R12", "pll off in settle", 32'(pll_en), 0);
            end
            @(negedge clk);
            chk("R12", "pll on after settle", 32'(pll_en), 32'(pexp));
            chk("R12", "cpu gated pre-lock", 32'(cpu_clk_en), 0);
            repeat (2) @(negedge clk);
            chk("R12", "cpu gated no lock", 32'(cpu_clk_en), 0);
            if (cfg[1]) begin
              pll_lock = 3'b011;
              @(negedge clk);
              chk("R12", "waits for extra pll", 32'(cpu_clk_en), 0);
            end
            pll_lock = pexp;
            @(negedge clk);
            chk("R12", "cpu on after lock", 32'(cpu_clk_en), 1);
            chk("R12", "periph on after lock", 32'(periph_clk_en), 32'(pat));
          end
        endcase
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule